// File: doc/BRIEF.md
# Decimating FIR Filter Section with Shared Coefficient Store

This block is one section of a cascaded low-pass decimator. It takes a stream of signed samples, each marked by a valid strobe, and keeps a short history of them. After every N accepted samples it runs a dot product of the newest samples against a run of taps. The taps are held in a coefficient memory that the whole cascade shares. The result is rounded, shifted down to the sample width, saturated, and issued as one decimated sample with a one-cycle valid pulse.

A single multiplier-accumulator does all the work and handles one tap per clock. The tap run starts at a per-section base offset in the shared memory. Each section has its own tap count (9-bit), decimation factor (4-bit) and rounding mode (2-bit).

Coefficients are 24-bit two's-complement values. They are loaded while the section is disabled. One write sets the load pointer, usually to 0. Each following data write stores one coefficient and moves the pointer on by one. This way the tap sets of several sections can be packed back to back, in cascade order.

Top module: `fir_decim_section`

## Requirements
- R1: A write with `coef_addr_we` loads the load pointer from `coef_wdata`. Each `coef_data_we` stores `coef_wdata` at the pointer and then increments it. Tap k of the section is read from address `sec_base + k`.
- R2: While `enable` is high, both coefficient write strobes are ignored. The memory contents and the load pointer keep their values.
- R3: Exactly one output is produced per N accepted samples, on the Nth one. N is `sec_decim`, and a value of 0 counts as 1. No other accepted sample raises `dec_valid`.
- R4: The output sum is the sum over k from 0 to T-1 of c[sec_base+k] times x[n-k]. T is `sec_taps` and x[n] is the newest accepted sample. Samples older than the first one accepted since `enable` rose count as zero.
- R5: `dec_valid` rises exactly T+3 clock cycles after the clock edge that accepts the sample completing the decimation period.
- R6: Coefficients are taken as fractions with 23 fraction bits. The sum is shifted right by 23 bits arithmetically. With `sec_round` = 1, 2^22 is added before the shift (round half up). With codes 0, 2 and 3 the shift alone is used (floor).
- R7: A shifted result outside the 16-bit signed range is clamped to 32767 or -32768.
- R8: While `enable` is low, input samples are ignored and no output is issued. Lowering `enable` clears the sample history and the decimation phase.
- R9: With a tap count of 0, no output is ever produced.
- R10: Under reset, `dec_valid` and `dec_data` are 0.
- R11: `dec_valid` is a single-cycle pulse. `dec_data` holds its last value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Section running; low clears history and locks coefficient writes |
| coef_addr_we | input | 1 | Load pointer write strobe |
| coef_data_we | input | 1 | Coefficient data write strobe |
| coef_wdata | input | 24 | Pointer value or coefficient value |
| sec_base | input | 9 | First coefficient address of this section |
| sec_taps | input | 9 | Tap count |
| sec_decim | input | 4 | Decimation factor (0 treated as 1) |
| sec_round | input | 2 | Rounding mode: 1 half up, others floor |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | 16 | Signed input sample |
| dec_valid | output | 1 | Decimated output strobe |
| dec_data | output | 16 | Signed decimated output |

## Verification
Each kind of internal fault shows at the ports. A wrong history pointer or fill count shows up in the first output after re-enabling, as a sum that includes stale or missing samples. A wrong tap index or base offset corrupts every output value. A wrong decimation phase moves the `dec_valid` pulse to the wrong input sample. A wrong pipeline flag moves the pulse away from cycle T+3 within one tap run. A moved load pointer only shows after a later data write, when that tap is read back through a one-tap configuration.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
// Shared constants and encodings for the decimating FIR section.
package fir_pkg;
    localparam int COEF_BITS  = 24;
    localparam int TAPCNT_BITS = 9;
    localparam int DECIM_BITS = 4;
    localparam int RND_BITS   = 2;

    // Rounding mode codes; codes not listed here narrow by floor.
    typedef enum logic [RND_BITS-1:0] {
        RND_FLOOR   = 2'd0,
        RND_HALF_UP = 2'd1
    } rnd_mode_e;
endpackage

// File: rtl/fir_coef_store.sv
`timescale 1ns/1ps
// Coefficient memory shared by the sections of a cascade.
// It has a load pointer that is set by an address write and advanced by each data write.
// Assumes: writes happen only while the owning filter is idle; lock blocks them.
module fir_coef_store #(
    parameter int COEF_W = 24,
    parameter int DEPTH  = 336,
    parameter int RA_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lock,
    input  logic                     addr_we,
    input  logic                     data_we,
    input  logic [COEF_W-1:0]        wdata,
    input  logic [RA_W-1:0]          rd_addr,
    output logic signed [COEF_W-1:0] rd_data
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = (RA_W > PTR_W) ? RA_W : PTR_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
    localparam logic [CW-1:0]    DEPTH_C = CW'(DEPTH);

    logic [COEF_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic              do_store;

    // store only when unlocked, pointer in range and no pointer load this cycle
    assign do_store = data_we && !addr_we && !lock && (wr_ptr < DEPTH_P);

    // load pointer: set by an address write, advanced by a stored coefficient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (!lock && addr_we) begin
            wr_ptr <= wdata[PTR_W-1:0];
        end else if (do_store) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
        end
    end

    // memory write port
    always_ff @(posedge clk) begin
        if (do_store) begin
            mem[AW'(wr_ptr)] <= wdata;
        end
    end

    // registered read port; out-of-range addresses read as zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (CW'(rd_addr) < DEPTH_C) begin
            rd_data <= mem[AW'(rd_addr)];
        end else begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/fir_sample_hist.sv
`timescale 1ns/1ps
// Circular history of accepted input samples.
// A read at index k returns the sample k steps older than the newest one,
// or zero when fewer than k+1 samples have been accepted since the last clear.
// Assumes: no write arrives while a tap run is reading the history.
module fir_sample_hist #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 128,
    parameter int IDX_W  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [DATA_W-1:0] rd_data
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CW    = (IDX_W > CNT_W) ? IDX_W : CNT_W;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic signed [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]            wr_ptr;
    logic [CNT_W-1:0]         fill;
    logic [AW-1:0]            rd_ptr;

    assign rd_ptr = wr_ptr - AW'(1) - rd_idx[AW-1:0];

    // write pointer and saturating fill count; clear empties the history
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + AW'(1);
            if (fill != FULL) begin
                fill <= fill + CNT_W'(1);
            end
        end
    end

    // sample storage
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // registered read; entries not yet filled read as zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (CW'(rd_idx) < CW'(fill)) begin
            rd_data <= mem[rd_ptr];
        end else begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/fir_mac_seq.sv
`timescale 1ns/1ps
// Tap sequencer with a single multiply-accumulate pipeline and output narrowing.
// A start pulse runs taps 0..T-1, one per cycle. The pipeline is: memory read,
// product register, accumulate, then round, shift, saturate and register the output.
// Assumes: configuration is stable during a run; a start while busy is dropped.
module fir_mac_seq import fir_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 24,
    parameter int OUT_W  = 16,
    parameter int TAP_W  = 9,
    parameter int FRAC   = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     start,
    input  logic [TAP_W-1:0]         taps,
    input  logic [RND_BITS-1:0]      rnd_mode,
    output logic [TAP_W-1:0]         tap_idx,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [DATA_W-1:0] samp,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + TAP_W;
    localparam int EXT_W  = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] HALF    = EXT_W'(1) <<< (FRAC - 1);
    localparam logic signed [EXT_W-1:0] OUT_MAX = {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] OUT_MIN = {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic                     busy;
    logic [TAP_W-1:0]         k;
    logic                     is_last;
    logic                     v1, f1, l1;
    logic                     v2, f2, l2;
    logic                     done;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc;
    logic signed [EXT_W-1:0]  biased;
    logic signed [EXT_W-1:0]  shifted;
    logic signed [OUT_W-1:0]  narrowed;

    assign is_last = busy && (k == taps - TAP_W'(1));
    assign tap_idx = k;

    // tap counter: one index per cycle while a run is active
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            busy <= 1'b0;
            k    <= '0;
        end else if (!busy) begin
            if (start && (taps != '0)) begin
                busy <= 1'b1;
                k    <= '0;
            end
        end else if (is_last) begin
            busy <= 1'b0;
        end else begin
            k <= k + TAP_W'(1);
        end
    end

    // pipeline flags follow each tap from read through accumulate
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            v1 <= 1'b0; f1 <= 1'b0; l1 <= 1'b0;
            v2 <= 1'b0; f2 <= 1'b0; l2 <= 1'b0;
            done <= 1'b0;
        end else begin
            v1 <= busy; f1 <= busy && (k == '0); l1 <= is_last;
            v2 <= v1;   f2 <= f1;                l2 <= l1;
            done <= v2 && l2;
        end
    end

    // multiply stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else begin
            prod <= coef * samp;
        end
    end

    // accumulate stage; the first tap of a run overwrites the old sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (v2) begin
            acc <= f2 ? ACC_W'(prod) : acc + ACC_W'(prod);
        end
    end

    // rounding bias, arithmetic shift and saturation of the finished sum
    always_comb begin
        biased = EXT_W'(acc);
        if (rnd_mode == RND_HALF_UP) begin
            biased = biased + HALF;
        end
        shifted = biased >>> FRAC;
        if (shifted > OUT_MAX) begin
            narrowed = OUT_MAX[OUT_W-1:0];
        end else if (shifted < OUT_MIN) begin
            narrowed = OUT_MIN[OUT_W-1:0];
        end else begin
            narrowed = shifted[OUT_W-1:0];
        end
    end

    // output register: one-cycle strobe, data held between results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= done && enable;
            if (done && enable) begin
                out_data <= narrowed;
            end
        end
    end
endmodule

// File: rtl/fir_decim_section.sv
`timescale 1ns/1ps
// One section of a cascaded decimating low-pass FIR.
// It accepts samples while enabled and counts them modulo the decimation factor.
// On the last sample of each period it starts a tap run that reads the
// coefficients at base+k and the history at k.
// Assumes: samples arrive no faster than one tap run per decimation period,
// and the configuration changes only while disabled.
module fir_decim_section import fir_pkg::*; #(
    parameter int DATA_W     = 16,
    parameter int COEF_W     = COEF_BITS,
    parameter int OUT_W      = 16,
    parameter int TAP_W      = TAPCNT_BITS,
    parameter int DEC_W      = DECIM_BITS,
    parameter int COEF_DEPTH = 336,
    parameter int HIST_DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     coef_addr_we,
    input  logic                     coef_data_we,
    input  logic [COEF_W-1:0]        coef_wdata,
    input  logic [TAP_W-1:0]         sec_base,
    input  logic [TAP_W-1:0]         sec_taps,
    input  logic [DEC_W-1:0]         sec_decim,
    input  logic [RND_BITS-1:0]      sec_round,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_data,
    output logic                     dec_valid,
    output logic signed [OUT_W-1:0]  dec_data
);
    localparam int RA_W = TAP_W + 1;
    localparam int FRAC = COEF_W - 1;

    logic                     accept;
    logic [DEC_W-1:0]         n_eff;
    logic [DEC_W-1:0]         phase;
    logic                     period_end;
    logic [TAP_W-1:0]         tap_idx;
    logic [RA_W-1:0]          coef_addr;
    logic signed [COEF_W-1:0] coef_q;
    logic signed [DATA_W-1:0] samp_q;

    assign accept     = smp_valid && enable;
    assign n_eff      = (sec_decim == '0) ? DEC_W'(1) : sec_decim;
    assign period_end = phase >= (n_eff - DEC_W'(1));
    assign coef_addr  = {1'b0, sec_base} + {1'b0, tap_idx};

    // decimation phase: counts accepted samples, wraps at the factor
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= '0;
        end else if (accept) begin
            phase <= period_end ? '0 : phase + DEC_W'(1);
        end
    end

    fir_coef_store #(
        .COEF_W (COEF_W),
        .DEPTH  (COEF_DEPTH),
        .RA_W   (RA_W)
    ) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (enable),
        .addr_we (coef_addr_we),
        .data_we (coef_data_we),
        .wdata   (coef_wdata),
        .rd_addr (coef_addr),
        .rd_data (coef_q)
    );

    fir_sample_hist #(
        .DATA_W (DATA_W),
        .DEPTH  (HIST_DEPTH),
        .IDX_W  (TAP_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!enable),
        .wr_en   (accept),
        .wr_data (smp_data),
        .rd_idx  (tap_idx),
        .rd_data (samp_q)
    );

    fir_mac_seq #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .OUT_W  (OUT_W),
        .TAP_W  (TAP_W),
        .FRAC   (FRAC)
    ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (accept && period_end),
        .taps      (sec_taps),
        .rnd_mode  (sec_round),
        .tap_idx   (tap_idx),
        .coef      (coef_q),
        .samp      (samp_q),
        .out_valid (dec_valid),
        .out_data  (dec_data)
    );
endmodule

// File: rtl/fir_decim_section_chk.sv
`timescale 1ns/1ps
// Property checker for fir_decim_section, attached by bind.
module fir_decim_section_chk #(
    parameter int OUT_W = 16,
    parameter int TAP_W = 9,
    parameter int PTR_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    enable,
    input logic                    coef_addr_we,
    input logic                    coef_data_we,
    input logic [TAP_W-1:0]        sec_taps,
    input logic                    dec_valid,
    input logic signed [OUT_W-1:0] dec_data,
    input logic [PTR_W-1:0]        wptr
);
    // R2
    coef_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (coef_addr_we || coef_data_we)) |=> $stable(wptr));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !dec_valid);

    // R9
    zero_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (sec_taps != '0));

    // R11
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> $stable(dec_data));
endmodule

bind fir_decim_section fir_decim_section_chk #(
    .OUT_W (OUT_W),
    .TAP_W (TAP_W),
    .PTR_W ($clog2(COEF_DEPTH + 1))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .coef_addr_we (coef_addr_we),
    .coef_data_we (coef_data_we),
    .sec_taps     (sec_taps),
    .dec_valid    (dec_valid),
    .dec_data     (dec_data),
    .wptr         (u_coef.wr_ptr)
);

// File: tb/sim_fir_decim_section.sv
`timescale 1ns/1ps
module sim_fir_decim_section;
    localparam int DATA_W = 16;
    localparam int COEF_W = 24;
    localparam int OUT_W  = 16;
    localparam int HIST   = 128;
    localparam int NCFG   = 5;
    // base, taps, decim, round, samples, seed
    localparam int TBL [NCFG][6] = '{
        '{0,  5, 2, 1, 8, 1},
        '{5,  3, 3, 0, 9, 2},
        '{8,  7, 1, 1, 6, 3},
        '{0, 15, 0, 2, 5, 4},
        '{15, 4, 4, 3, 8, 5}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic enable = 0;
    logic coef_addr_we = 0;
    logic coef_data_we = 0;
    logic [COEF_W-1:0] coef_wdata = '0;
    logic [8:0] sec_base = '0;
    logic [8:0] sec_taps = '0;
    logic [3:0] sec_decim = '0;
    logic [1:0] sec_round = '0;
    logic smp_valid = 0;
    logic signed [DATA_W-1:0] smp_data = '0;
    logic dec_valid;
    logic signed [OUT_W-1:0] dec_data;

    fir_decim_section u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .coef_addr_we(coef_addr_we), .coef_data_we(coef_data_we), .coef_wdata(coef_wdata),
        .sec_base(sec_base), .sec_taps(sec_taps), .sec_decim(sec_decim), .sec_round(sec_round),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .dec_valid(dec_valid), .dec_data(dec_data)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    longint cref [336];
    longint bh [4096];
    int bn = 0, ph = 0;
    int m_base = 0, m_taps = 0, m_decim = 1, m_rnd = 0;
    bit m_en = 0;

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_addr(input int a);
        coef_wdata = COEF_W'(a); coef_addr_we = 1; tick(); coef_addr_we = 0;
    endtask

    task automatic wr_data(input longint v);
        coef_wdata = COEF_W'(v); coef_data_we = 1; tick(); coef_data_we = 0;
    endtask

    // model of R4, R6, R7
    function automatic longint ref_out();
        longint s = 0;
        for (int k = 0; k < m_taps; k++)
            if (k < bn && k < HIST) s += cref[m_base + k] * bh[bn - 1 - k];
        if (m_rnd == 1) s += longint'(1) <<< 22;
        s = s >>> 23;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic configure(input int b, input int t, input int d, input int r);
        enable = 0; sec_base = 9'(b); sec_taps = 9'(t); sec_decim = 4'(d); sec_round = 2'(r);
        tick(); enable = 1; tick();
        m_base = b; m_taps = t; m_decim = d; m_rnd = r; bn = 0; ph = 0; m_en = 1;
    endtask

    task automatic feed(input int x, input string tag);
        bit fire;
        longint exp;
        int seen_at;
        longint seen_val;
        smp_data = DATA_W'(x); smp_valid = 1; tick(); smp_valid = 0;
        fire = 0;
        if (m_en) begin
            bh[bn] = x; bn++; ph++;
            if (ph >= ((m_decim == 0) ? 1 : m_decim)) begin
                ph = 0; fire = (m_taps != 0);
            end
        end
        exp = ref_out();
        seen_at = 0; seen_val = 0;
        for (int n = 1; n <= m_taps + 6; n++) begin
            tick();
            if (dec_valid && seen_at == 0) begin seen_at = n; seen_val = longint'(dec_data); end
        end
        if (fire) begin
            check(seen_at == m_taps + 3, {tag, " R5 latency"}, seen_at, m_taps + 3);
            check(seen_val == exp, {tag, " value"}, seen_val, exp);
            check(longint'(dec_data) == exp, {tag, " R11 hold"}, longint'(dec_data), exp);
        end else begin
            check(seen_at == 0, {tag, " R3 no output expected"}, seen_at, 0);
        end
    endtask

    initial begin
        // R10 reset state
        repeat (4) tick();
        check(dec_valid == 0, "R10 valid in reset", dec_valid, 0);
        check(dec_data == 0, "R10 data in reset", dec_data, 0);
        rst_n = 1; tick();
        check(dec_valid == 0 && dec_data == 0, "R10 after reset", dec_data, 0);

        // R1 load coefficients back to back
        wr_addr(0);
        for (int i = 0; i < 40; i++) begin
            cref[i] = longint'(((i * 37 + 11) % 97) - 48) * 20011;
            wr_data(cref[i]);
        end
        cref[40] = 64'h400000;
        wr_data(cref[40]);
        for (int i = 41; i < 44; i++) begin cref[i] = 64'h7FFFFF; wr_data(cref[i]); end

        // table of configurations, R1 R3 R4 R6
        for (int c = 0; c < NCFG; c++) begin
            configure(TBL[c][0], TBL[c][1], TBL[c][2], TBL[c][3]);
            for (int j = 0; j < TBL[c][4]; j++)
                feed((((j * 53 + TBL[c][5] * 71) % 201) - 100) * 97, "R1 R4 table");
        end

        // R6 rounding halves
        configure(40, 1, 1, 1);
        feed(3, "R6 half up");
        check(dec_data == 2, "R6 +1.5 rounds to 2", dec_data, 2);
        feed(-3, "R6 half up");
        check(dec_data == -1, "R6 -1.5 rounds to -1", dec_data, -1);
        configure(40, 1, 1, 0);
        feed(3, "R6 floor");
        check(dec_data == 1, "R6 +1.5 floors to 1", dec_data, 1);
        feed(-3, "R6 floor");
        check(dec_data == -2, "R6 -1.5 floors to -2", dec_data, -2);

        // R7 saturation
        configure(41, 3, 1, 0);
        for (int j = 0; j < 3; j++) feed(32767, "R7 high");
        check(dec_data == 32767, "R7 clamp high", dec_data, 32767);
        for (int j = 0; j < 3; j++) feed(-32768, "R7 low");
        check(dec_data == -32768, "R7 clamp low", dec_data, -32768);

        // R2 writes ignored while enabled
        configure(0, 5, 2, 1);
        wr_addr(0);
        for (int j = 0; j < 3; j++) wr_data(24'h12345);
        for (int j = 0; j < 6; j++) feed(j * 311 - 700, "R2 coefs unchanged");
        enable = 0; tick();
        cref[44] = 777777;
        wr_data(cref[44]);
        configure(44, 1, 1, 0);
        feed(1000, "R2 pointer kept");
        check(dec_data == 92, "R2 pointer kept at 44", dec_data, 92);

        // R8 disable ignores samples and clears history
        configure(0, 5, 1, 1);
        for (int j = 0; j < 3; j++) feed(4000 - j * 900, "R8 prefill");
        enable = 0; m_en = 0; bn = 0; ph = 0; tick();
        feed(9999, "R8 ignored while disabled");
        feed(-9999, "R8 ignored while disabled");
        enable = 1; m_en = 1; tick();
        feed(500, "R8 history cleared");

        // R9 zero taps
        configure(0, 0, 1, 0);
        for (int j = 0; j < 3; j++) feed(1234, "R9 zero taps");

        finish_up();
    end
endmodule